// File: doc/BRIEF.md
# Level-to-Pulse Transmitter with Idle Refresh

This block drives the transmit end of a one-bit link that carries only short pulses, not levels. It follows a level input and turns each change into a single-cycle pulse on one of two outputs. A low-to-high change gives a pulse on `set_pulse`. A high-to-low change gives a pulse on `clr_pulse`. The receiver rebuilds the level from these pulses, so a receiver that missed a pulse, or that powered up late, could hold the wrong value for as long as the input stays still.

To prevent that, the block times how long the input has been quiet. When the input has shown no change for `IDLE_CYC` clock cycles after the last pulse, the block sends a refresh pulse on the output that matches the present level. While the input stays steady, it repeats that refresh every `RFR_CYC` cycles. Every real edge restarts the quiet-time count. The input is asynchronous to the clock and first passes through a two-flop synchroniser. Both outputs are registered.

Top module: `level_pulse_tx`

## Requirements
- R1: A low-to-high change of `din` produces exactly one `set_pulse`. When `din` is first sampled high at rising clock edge k, the pulse is high during the cycle that follows edge k+2.
- R2: A high-to-low change of `din` produces exactly one `clr_pulse`, with the same latency as R1.
- R3: Each pulse lasts exactly one clock cycle. No pulse appears in a cycle for which neither an edge nor a refresh is due.
- R4: `set_pulse` and `clr_pulse` are never high in the same cycle.
- R5: After an edge pulse, if the input stays steady, a refresh pulse follows exactly `IDLE_CYC` cycles later. It is a `set_pulse` if the synchronised level is 1 and a `clr_pulse` if it is 0.
- R6: After a refresh pulse, while the input stays steady, further refresh pulses of the same kind follow every `RFR_CYC` cycles.
- R7: Every edge pulse restarts the quiet-time count from zero, so the next refresh comes `IDLE_CYC` cycles after it. When an edge pulse and a refresh fall due in the same cycle, only the edge pulse is sent.
- R8: When `din` toggles on every clock cycle, every change produces its own pulse, so the outputs alternate set and clear with none lost.
- R9: While `rst_n` is low, both outputs are 0. After reset is released, the first pulse reflects the synchronised input level and appears no more than `RFR_CYC` cycles later. With `din` held low from reset, it is a `clr_pulse` in the cycle after rising edge `RFR_CYC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Level input to be sent; may be asynchronous to `clk` |
| set_pulse | output | 1 | One-cycle pulse meaning "the level is now 1" |
| clr_pulse | output | 1 | One-cycle pulse meaning "the level is now 0" |

## Verification
An input edge and a refresh can fall due in the same cycle. The bench provokes this on purpose: its own model counts the steady cycles and flips `din` at exactly the point where that input value would otherwise have produced a refresh pulse. This is done for both polarities, and both during the first quiet interval and during repeated refreshing. The scoreboard then expects only the edge pulse in that cycle, with no second pulse beside it. It also expects the next refresh a full `IDLE_CYC` cycles later, which shows that the edge, not the refresh, restarted the count.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_SET  = 2'd1,
    PK_CLR  = 2'd2
  } pulse_kind_t;

  // An edge always wins; a due refresh only speaks when the level is steady.
  function automatic pulse_kind_t classify(input logic now_lvl,
                                           input logic prev_lvl,
                                           input logic due);
    if (now_lvl && !prev_lvl) return PK_SET;
    if (!now_lvl && prev_lvl) return PK_CLR;
    if (due) return now_lvl ? PK_SET : PK_CLR;
    return PK_NONE;
  endfunction

  // Quiet interval that applies in the current phase of the timer.
  function automatic int unsigned wait_limit(input logic refreshing,
                                             input int unsigned idle_c,
                                             input int unsigned rfr_c);
    return refreshing ? rfr_c : idle_c;
  endfunction

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lpt_timer.sv
module lpt_timer #(
  parameter int unsigned IDLE_CYC = 48,
  parameter int unsigned RFR_CYC  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic due_o
);
  import lpt_pkg::*;

  localparam int unsigned MAXL = (IDLE_CYC > RFR_CYC) ? IDLE_CYC : RFR_CYC;
  localparam int unsigned CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q;
  logic          refr_q;   // 1: in periodic-refresh phase
  logic [CW-1:0] lim_m1;

  assign lim_m1 = CW'(wait_limit(refr_q, IDLE_CYC, RFR_CYC) - 1);
  assign due_o  = (cnt_q == lim_m1);

  // Reset enters the refresh phase so the first level report comes early.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      refr_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q  <= '0;
      refr_q <= 1'b0;
    end else if (due_o) begin
      cnt_q  <= '0;
      refr_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R7: an edge restarts the quiet count and leaves the refresh phase.
  a_r7_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0) && !refr_q);

  // R6: the count never passes the longer interval.
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAXL));
endmodule

// File: rtl/lpt_encoder.sv
module lpt_encoder (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic due_i,
  output logic edge_o,
  output logic set_o,
  output logic clr_o
);
  import lpt_pkg::*;

  logic        lvl_prev_q;
  pulse_kind_t kind;

  assign kind   = classify(lvl_i, lvl_prev_q, due_i);
  assign edge_o = lvl_i ^ lvl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= 1'b0;
      set_o      <= 1'b0;
      clr_o      <= 1'b0;
    end else begin
      lvl_prev_q <= lvl_i;
      set_o      <= (kind == PK_SET);
      clr_o      <= (kind == PK_CLR);
    end
  end

  a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i && !lvl_prev_q) |=> set_o);

  a_r2_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_i && lvl_prev_q) |=> clr_o);

  a_r3_set_single: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |=> !set_o);

  a_r3_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> !clr_o);

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_o && clr_o));
endmodule

// File: rtl/level_pulse_tx.sv
module level_pulse_tx #(
  parameter int unsigned IDLE_CYC    = 48,
  parameter int unsigned RFR_CYC     = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic set_pulse,
  output logic clr_pulse
);
  logic lvl_sync;
  logic edge_evt;
  logic refresh_due;

  lpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d_i (din),
    .q_o (lvl_sync)
  );

  lpt_timer #(.IDLE_CYC(IDLE_CYC), .RFR_CYC(RFR_CYC)) u_timer (
    .clk (clk),
    .rst_n (rst_n),
    .restart_i (edge_evt),
    .due_o (refresh_due)
  );

  lpt_encoder u_enc (
    .clk (clk),
    .rst_n (rst_n),
    .lvl_i (lvl_sync),
    .due_i (refresh_due),
    .edge_o (edge_evt),
    .set_o (set_pulse),
    .clr_o (clr_pulse)
  );

  // R5: a refresh on a steady level reports that level.
  a_r5_refresh_high: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_due && !edge_evt && lvl_sync) |=> set_pulse && !clr_pulse);

  a_r5_refresh_low: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_due && !edge_evt && !lvl_sync) |=> clr_pulse && !set_pulse);

  // R7: an edge and a due refresh together yield only the edge pulse.
  a_r7_edge_beats_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_due && edge_evt) |=> (set_pulse == lvl_sync) && (clr_pulse != lvl_sync));
endmodule

// File: tb/level_pulse_tx_bench.sv
module level_pulse_tx_bench;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned IDLE_C = 24;
  localparam int unsigned RFR_C  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic set_pulse, clr_pulse;

  level_pulse_tx #(.IDLE_CYC(IDLE_C), .RFR_CYC(RFR_C)) u_level_pulse_tx (
    .clk (clk), .rst_n (rst_n), .din (din),
    .set_pulse (set_pulse), .clr_pulse (clr_pulse)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic  exp_set;
    logic  exp_clr;
    string tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    mon_on = 0;
  bit    done = 0;
  string scen = "R9 power-up";

  // Bench-side model state
  logic m_prev = 1'b0;
  int   since = 2;
  bit   refreshing = 1;

  function automatic int thr();
    return refreshing ? RFR_C : IDLE_C;
  endfunction

  task automatic push(input logic s, input logic c, input string t);
    item_t it;
    it.exp_set = s; it.exp_clr = c; it.tag = t;
    q.push_back(it);
  endtask

  // Driver: applies one input value per cycle and predicts its result.
  task automatic step(input logic v);
    @(negedge clk);
    din = v;
    if (v != m_prev) begin
      push(v, !v, v ? "R1" : "R2");
      since = 0;
      refreshing = 0;
    end else begin
      since++;
      if (since == thr()) begin
        push(v, !v, refreshing ? "R6" : "R5");
        since = 0;
        refreshing = 1;
      end else begin
        push(1'b0, 1'b0, "R3");
      end
    end
    m_prev = v;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) step(m_prev);
  endtask

  // Flip the input exactly where a refresh would have fallen due.
  task automatic collide();
    while (since + 1 != thr()) step(m_prev);
    step(!m_prev);
  endtask

  // Monitor: compares each cycle's outputs with the queued prediction.
  always @(posedge clk) begin
    #2;
    if (mon_on && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (set_pulse !== it.exp_set || clr_pulse !== it.exp_clr) begin
        errors++;
        $display("FAIL %s (%s): set/clr actual %b%b expected %b%b at %0t",
                 it.tag, scen, set_pulse, clr_pulse, it.exp_set, it.exp_clr, $time);
      end
      checks++;
      if (set_pulse && clr_pulse) begin
        errors++;
        $display("FAIL R4 (%s): set/clr actual 11 expected not both", scen);
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: outputs stay low while reset is held.
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (set_pulse !== 1'b0 || clr_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R9: set/clr actual %b%b expected 00 in reset", set_pulse, clr_pulse);
    end
    @(negedge clk);
    rst_n = 1'b1;
    din = 1'b0;
    push(1'b0, 1'b0, "R3");
    push(1'b0, 1'b0, "R3");
    since++;
    if (since == thr()) begin
      push(1'b0, 1'b1, "R9"); since = 0;
    end else begin
      push(1'b0, 1'b0, "R9");
    end
    mon_on = 1;

    scen = "R9 power-up";     hold(RFR_C + 2);
    scen = "R6 steady low";   hold(2 * RFR_C);
    scen = "R1 rise then R5"; step(1'b1); hold(IDLE_C + 2 * RFR_C + 3);
    scen = "R2 fall then R5"; step(1'b0); hold(IDLE_C + RFR_C + 2);
    scen = "R8 toggle";
    for (int i = 0; i < 16; i++) step(!m_prev);
    hold(3);
    scen = "R7 restart";
    for (int i = 0; i < 4; i++) begin
      step(!m_prev);
      hold(IDLE_C - 3);
    end
    hold(IDLE_C + 2);
    scen = "R7 collide refresh phase"; collide(); hold(5);
    scen = "R7 collide idle phase";    collide(); hold(IDLE_C + RFR_C + 1);
    collide(); collide(); hold(IDLE_C + 2);
    scen = "R8 toggle pairs";
    for (int i = 0; i < 6; i++) begin step(1'b1); step(1'b1); step(1'b0); end
    hold(IDLE_C + RFR_C + 4);

    while (q.size() != 0) @(posedge clk);
    #5;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule